// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This block follows a processor core through its power modes and drives the enables that put those modes into effect. It has five modes. In run, everything is clocked. In light sleep, only the CPU clock is gated and the peripherals keep running. In software standby, both the CPU and peripheral clocks are halted. Hardware standby is entered from a dedicated active-low pin and halts everything. The fifth mode is a settling phase that every reset-style wake passes through.

A sleep-instruction strobe picks the depth from a standby-select bit. Each depth is left only on its own set of wake events. Light sleep is left on an interrupt or a DMA address error, which resume execution, or on a power-on or manual reset, which restart it. Software standby ignores everything except a fresh rising edge on NMI and a power-on reset. Leaving it always takes the device through a reset. Hardware standby is left only when the pin is high and a power-on reset request arrives.

Every reset-style wake has the same sequence. The peripheral reset is held, a one-cycle wake-reset pulse is given, and both clocks stay gated for a settling length that software provides. The controller then returns to run. The control bits that software would normally write into registers appear here as plain inputs.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the block is in run: CPU and peripheral clock enables are 1; peripheral reset, pin tri-state and wake-reset are 0; the RAM retention enable is 1.
- R2: A sleep strobe with the standby-select bit at 0 enters light sleep on the next clock. The CPU clock enable goes to 0 and the peripheral clock enable stays at 1.
- R3: In light sleep, an interrupt request or a DMA address error returns the block to run on the next clock without a wake-reset pulse.
- R4: A power-on or manual reset request in run or light sleep starts the settle sequence on the next clock. In that cycle the peripheral reset and wake-reset are 1 and both clock enables are 0.
- R5: A sleep strobe with the standby-select bit at 1 enters software standby on the next clock with both clock enables at 0. In this mode the pin tri-state output follows the pin high-impedance bit.
- R6: In software standby, interrupts, DMA address errors, manual reset requests and an NMI level that was already high before entry have no effect.
- R7: An NMI rising edge wakes software standby. The settle sequence begins on the third clock edge after the rise, and wake-reset is 1 for exactly one cycle.
- R8: The settle sequence keeps both clock enables at 0 and the peripheral reset at 1 for settle_len_i+1 cycles. settle_len_i is sampled on entry. The block is in run on the following cycle.
- R9: A power-on reset request in software standby starts the settle sequence on the next clock.
- R10: A low level on hw_stby_n_i enters hardware standby on the next clock from any mode, with priority over all other events. Both clock enables are 0, and the peripheral reset and pin tri-state are 1.
- R11: Hardware standby is left only when hw_stby_n_i is high and a power-on reset request is present together. The settle sequence then begins on the next clock.
- R12: In hardware standby, the RAM retention enable equals the inverse of ram_en_i in the cycle the entry was decided. It ignores later changes of ram_en_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slp_strobe_i | input | 1 | Sleep instruction executed (one-cycle strobe) |
| stby_sel_i | input | 1 | 1: strobe selects software standby, 0: light sleep |
| pin_hiz_i | input | 1 | 1: pins float in software standby, 0: pins hold |
| ram_en_i | input | 1 | RAM enable bit; must be 0 before hardware standby to keep contents |
| hw_stby_n_i | input | 1 | Hardware standby pin, active low, already synchronous |
| nmi_i | input | 1 | Non-maskable interrupt input (asynchronous) |
| irq_i | input | 1 | Maskable interrupt request |
| dma_err_i | input | 1 | DMA address error |
| por_req_i | input | 1 | Power-on reset request |
| mrst_req_i | input | 1 | Manual reset request |
| settle_len_i | input | CNT_W | Settling length minus one, in cycles |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| per_rst_o | output | 1 | Peripheral reset |
| ram_hold_o | output | 1 | RAM retention enable |
| pin_tri_o | output | 1 | Pin tri-state control |
| wake_rst_o | output | 1 | One-cycle wake-reset pulse |

## Verification
A corrupted mode register becomes visible at the clock-enable outputs one cycle after the event that should have moved it. The pattern of the two enables together with the peripheral reset tells the five modes apart, so the bench can pin every transition to a single edge. A wrong NMI synchroniser depth shifts the wake by whole cycles, and the bench samples exactly on the third edge. A wrong settle count changes when the CPU clock enable returns by one or more cycles. A RAM retention flag captured at the wrong time shows up while the block is still in hardware standby.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [2:0] {
    MODE_RUN    = 3'd0,
    MODE_SLEEP  = 3'd1,
    MODE_SSTBY  = 3'd2,
    MODE_HSTBY  = 3'd3,
    MODE_SETTLE = 3'd4
  } pwr_mode_e;
endpackage

// File: rtl/pwr_nmi_edge.sv
module pwr_nmi_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic nmi_i,
  output logic rise_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_ni) begin
          if (!rst_ni) sync_q[0] <= 1'b0;
          else         sync_q[0] <= nmi_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_ni) begin
          if (!rst_ni) sync_q[g] <= 1'b0;
          else         sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= sync_q[SYNC_STAGES-1];
  end

  assign rise_o = sync_q[SYNC_STAGES-1] & ~last_q;

  // R7: an edge is a single-cycle event
  assert_rise_single_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/pwr_settle_cnt.sv
module pwr_settle_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)              cnt_d = len_i;
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q == '0);

  // R8: count never wraps below zero
  assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (!load_i && cnt_q == '0) |=> cnt_q == '0);
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_pkg::*;
(
  input  logic clk,
  input  logic rst_ni,
  input  logic slp_strobe_i,
  input  logic stby_sel_i,
  input  logic pin_hiz_i,
  input  logic ram_en_i,
  input  logic hw_stby_n_i,
  input  logic nmi_rise_i,
  input  logic irq_i,
  input  logic dma_err_i,
  input  logic por_req_i,
  input  logic mrst_req_i,
  input  logic settle_done_i,
  output logic settle_load_o,
  output logic cpu_clk_en_o,
  output logic per_clk_en_o,
  output logic per_rst_o,
  output logic ram_hold_o,
  output logic pin_tri_o,
  output logic wake_rst_o
);
  pwr_mode_e st_q, st_d;
  logic      wake_q, wake_d;
  logic      keep_q, keep_d;
  logic      enter_settle, enter_hstby;

  always_comb begin
    st_d = st_q;
    if (!hw_stby_n_i) begin
      st_d = MODE_HSTBY;
    end else begin
      unique case (st_q)
        MODE_RUN: begin
          if (por_req_i || mrst_req_i) st_d = MODE_SETTLE;
          else if (slp_strobe_i)       st_d = stby_sel_i ? MODE_SSTBY : MODE_SLEEP;
        end
        MODE_SLEEP: begin
          if (por_req_i || mrst_req_i)  st_d = MODE_SETTLE;
          else if (irq_i || dma_err_i)  st_d = MODE_RUN;
        end
        MODE_SSTBY: begin
          if (por_req_i || nmi_rise_i) st_d = MODE_SETTLE;
        end
        MODE_HSTBY: begin
          if (por_req_i) st_d = MODE_SETTLE;
        end
        MODE_SETTLE: begin
          if (settle_done_i) st_d = MODE_RUN;
        end
        default: st_d = MODE_RUN;
      endcase
    end
  end

  assign enter_settle  = (st_d == MODE_SETTLE) && (st_q != MODE_SETTLE);
  assign enter_hstby   = (st_d == MODE_HSTBY) && (st_q != MODE_HSTBY);
  assign settle_load_o = enter_settle;
  assign wake_d        = enter_settle;
  assign keep_d        = enter_hstby ? ~ram_en_i : keep_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= MODE_RUN;
      wake_q <= 1'b0;
      keep_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      wake_q <= wake_d;
      keep_q <= keep_d;
    end
  end

  always_comb begin
    cpu_clk_en_o = 1'b0;
    per_clk_en_o = 1'b0;
    per_rst_o    = 1'b0;
    pin_tri_o    = 1'b0;
    ram_hold_o   = 1'b1;
    unique case (st_q)
      MODE_RUN:    begin cpu_clk_en_o = 1'b1; per_clk_en_o = 1'b1; end
      MODE_SLEEP:  per_clk_en_o = 1'b1;
      MODE_SSTBY:  pin_tri_o = pin_hiz_i;
      MODE_HSTBY:  begin per_rst_o = 1'b1; pin_tri_o = 1'b1; ram_hold_o = keep_q; end
      MODE_SETTLE: per_rst_o = 1'b1;
      default:     per_rst_o = 1'b1;
    endcase
  end
  assign wake_rst_o = wake_q;

  // R10: pin low forces all clocks off on the next cycle
  assert_hstby_entry_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    !hw_stby_n_i |=> (!cpu_clk_en_o && !per_clk_en_o && per_rst_o && pin_tri_o));
  // R7: wake pulse is one cycle wide
  assert_wake_pulse_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    wake_rst_o |=> !wake_rst_o);
  // R6: software standby holds without its own wake events
  assert_sstby_hold_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == MODE_SSTBY && hw_stby_n_i && !por_req_i && !nmi_rise_i) |=> st_q == MODE_SSTBY);
  // R12: retention flag frozen while in hardware standby
  assert_ram_stable_R12: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == MODE_HSTBY && st_d == MODE_HSTBY) |=> $stable(ram_hold_o));
  // R4: wake pulse only while clocks are gated and peripherals held in reset
  assert_wake_gated_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    wake_rst_o |-> (per_rst_o && !cpu_clk_en_o && !per_clk_en_o));
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slp_strobe_i,
  input  logic             stby_sel_i,
  input  logic             pin_hiz_i,
  input  logic             ram_en_i,
  input  logic             hw_stby_n_i,
  input  logic             nmi_i,
  input  logic             irq_i,
  input  logic             dma_err_i,
  input  logic             por_req_i,
  input  logic             mrst_req_i,
  input  logic [CNT_W-1:0] settle_len_i,
  output logic             cpu_clk_en_o,
  output logic             per_clk_en_o,
  output logic             per_rst_o,
  output logic             ram_hold_o,
  output logic             pin_tri_o,
  output logic             wake_rst_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       nmi_rise, settle_load, settle_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pwr_nmi_edge #(.SYNC_STAGES(SYNC_STAGES)) i_nmi (
    .clk(clk), .rst_ni(rst_int_n), .nmi_i(nmi_i), .rise_o(nmi_rise)
  );

  pwr_settle_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk(clk), .rst_ni(rst_int_n), .load_i(settle_load),
    .len_i(settle_len_i), .done_o(settle_done)
  );

  pwr_mode_fsm i_fsm (
    .clk(clk), .rst_ni(rst_int_n),
    .slp_strobe_i(slp_strobe_i), .stby_sel_i(stby_sel_i),
    .pin_hiz_i(pin_hiz_i), .ram_en_i(ram_en_i), .hw_stby_n_i(hw_stby_n_i),
    .nmi_rise_i(nmi_rise), .irq_i(irq_i), .dma_err_i(dma_err_i),
    .por_req_i(por_req_i), .mrst_req_i(mrst_req_i),
    .settle_done_i(settle_done), .settle_load_o(settle_load),
    .cpu_clk_en_o(cpu_clk_en_o), .per_clk_en_o(per_clk_en_o),
    .per_rst_o(per_rst_o), .ram_hold_o(ram_hold_o),
    .pin_tri_o(pin_tri_o), .wake_rst_o(wake_rst_o)
  );

  // R2: CPU clock never runs while peripheral clock is stopped
  assert_clk_order_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    cpu_clk_en_o |-> per_clk_en_o);
endmodule

// File: tb/test_pwr_mode_ctrl.sv
module test_pwr_mode_ctrl;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slp_strobe_i = 0, stby_sel_i = 0, pin_hiz_i = 0, ram_en_i = 0;
  logic hw_stby_n_i = 1, nmi_i = 0, irq_i = 0, dma_err_i = 0;
  logic por_req_i = 0, mrst_req_i = 0;
  logic [CNT_W-1:0] settle_len_i = 8'd3;
  logic cpu_clk_en_o, per_clk_en_o, per_rst_o, ram_hold_o, pin_tri_o, wake_rst_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  pwr_mode_ctrl #(.CNT_W(CNT_W)) i_pwr_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .slp_strobe_i(slp_strobe_i), .stby_sel_i(stby_sel_i),
    .pin_hiz_i(pin_hiz_i), .ram_en_i(ram_en_i), .hw_stby_n_i(hw_stby_n_i),
    .nmi_i(nmi_i), .irq_i(irq_i), .dma_err_i(dma_err_i), .por_req_i(por_req_i),
    .mrst_req_i(mrst_req_i), .settle_len_i(settle_len_i),
    .cpu_clk_en_o(cpu_clk_en_o), .per_clk_en_o(per_clk_en_o), .per_rst_o(per_rst_o),
    .ram_hold_o(ram_hold_o), .pin_tri_o(pin_tri_o), .wake_rst_o(wake_rst_o)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // vector: {cpu, per, per_rst, tri, wake}
  task automatic chk_mode(input string req, input logic [4:0] exp);
    chk(req, "cpu_clk_en", cpu_clk_en_o, exp[4]);
    chk(req, "per_clk_en", per_clk_en_o, exp[3]);
    chk(req, "per_rst",    per_rst_o,    exp[2]);
    chk(req, "pin_tri",    pin_tri_o,    exp[1]);
    chk(req, "wake_rst",   wake_rst_o,   exp[0]);
  endtask

  task automatic t_reset;
    rst_n = 0; tick(2); rst_n = 1; tick(4);
    chk_mode("R1", 5'b11000);
    chk("R1", "ram_hold", ram_hold_o, 1'b1);
  endtask

  task automatic t_sleep;
    slp_strobe_i = 1; stby_sel_i = 0; tick(1); slp_strobe_i = 0;
    chk_mode("R2", 5'b01000);
    tick(2); chk_mode("R2", 5'b01000);
    irq_i = 1; tick(1); irq_i = 0;
    chk_mode("R3", 5'b11000);
    slp_strobe_i = 1; tick(1); slp_strobe_i = 0;
    dma_err_i = 1; tick(1); dma_err_i = 0;
    chk_mode("R3", 5'b11000);
  endtask

  task automatic t_reset_path;
    settle_len_i = 3;
    slp_strobe_i = 1; tick(1); slp_strobe_i = 0;
    mrst_req_i = 1; tick(1); mrst_req_i = 0;
    chk_mode("R4", 5'b00101);
    tick(1); chk_mode("R4", 5'b00100);
    tick(2); chk_mode("R8", 5'b00100);
    tick(1); chk_mode("R8", 5'b11000);
    por_req_i = 1; tick(1); por_req_i = 0;
    chk_mode("R4", 5'b00101);
    tick(4); chk_mode("R8", 5'b11000);
  endtask

  task automatic t_sstby;
    settle_len_i = 3;
    nmi_i = 1; tick(4);
    pin_hiz_i = 1; slp_strobe_i = 1; stby_sel_i = 1; tick(1); slp_strobe_i = 0;
    chk_mode("R5", 5'b00010);
    pin_hiz_i = 0; tick(1);
    chk_mode("R5", 5'b00000);
    tick(5); chk_mode("R6", 5'b00000);
    irq_i = 1; dma_err_i = 1; mrst_req_i = 1; tick(3);
    irq_i = 0; dma_err_i = 0; mrst_req_i = 0;
    chk_mode("R6", 5'b00000);
    nmi_i = 0; tick(4);
    nmi_i = 1; tick(2);
    chk_mode("R7", 5'b00000);
    tick(1); chk_mode("R7", 5'b00101);
    tick(1); chk_mode("R7", 5'b00100);
    tick(2); chk_mode("R8", 5'b00100);
    tick(1); chk_mode("R8", 5'b11000);
    nmi_i = 0; tick(2);
    settle_len_i = 0;
    slp_strobe_i = 1; tick(1); slp_strobe_i = 0;
    chk_mode("R9", 5'b00000);
    por_req_i = 1; tick(1); por_req_i = 0;
    chk_mode("R9", 5'b00101);
    tick(1); chk_mode("R8", 5'b11000);
  endtask

  task automatic t_hstby;
    settle_len_i = 3;
    ram_en_i = 1; hw_stby_n_i = 0; tick(1);
    chk_mode("R10", 5'b00110);
    chk("R12", "ram_hold", ram_hold_o, 1'b0);
    ram_en_i = 0; tick(1);
    chk("R12", "ram_hold", ram_hold_o, 1'b0);
    por_req_i = 1; tick(2); por_req_i = 0;
    chk_mode("R11", 5'b00110);
    hw_stby_n_i = 1; tick(2);
    chk_mode("R11", 5'b00110);
    por_req_i = 1; tick(1); por_req_i = 0;
    chk_mode("R11", 5'b00101);
    tick(4); chk_mode("R8", 5'b11000);
    slp_strobe_i = 1; stby_sel_i = 0; tick(1); slp_strobe_i = 0;
    ram_en_i = 0; hw_stby_n_i = 0; irq_i = 1; tick(1); irq_i = 0;
    chk_mode("R10", 5'b00110);
    chk("R12", "ram_hold", ram_hold_o, 1'b1);
    ram_en_i = 1; tick(1);
    chk("R12", "ram_hold", ram_hold_o, 1'b1);
    hw_stby_n_i = 1; por_req_i = 1; tick(1); por_req_i = 0;
    tick(4); chk_mode("R11", 5'b11000);
    chk("R1", "ram_hold", ram_hold_o, 1'b1);
  endtask

  logic finished = 1'b0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset;
    t_sleep;
    t_reset_path;
    t_sstby;
    t_hstby;
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule